// File: doc/BRIEF.md
# Stack Limit Guard for Block Load/Store

This unit sits in the execute stage of a 32-bit processor, beside the block transfer sequencer. When a load-multiple or store-multiple instruction is issued, it decodes the register mask, the direction bit and the base-update bit. From these it works out how many bytes the instruction moves and the lowest address it touches. It also works out the value that goes back into the base register.

If checking is on, the base register is the stack pointer and the base is updated, the unit compares the lowest address against the programmed stack limit. It gives its verdict one cycle after the start strobe, before the sequencer issues any beat. A permit pulse lets the transfer proceed. A fault pulse blocks every beat of the instruction and asks for an exception. The fault is raised even when the stack pointer moves upward: in that case the original stack pointer is the lowest address and it is already below the limit. Beat sequencing and exception entry belong to the neighbouring logic.

Top module: `lsm_stack_guard`

## Requirements
- R1: While reset is held, and on the first cycles after it is released, `permitStb` and `faultFlag` are 0 and `startAddr`, `wbValue` and `wbFlag` are 0.
- R2: The transfer size is 4 bytes times the number of set bits in instruction bits [15:0]. When bit 24 is 0 (increment form), `startAddr` is the base and `wbValue` is the base plus the size.
- R3: When instruction bit 24 is 1 (decrement-before form), both `startAddr` and `wbValue` are the base minus the transfer size, modulo 2^32.
- R4: All outputs are registered. They take their new values in the cycle after a cycle with `startStb` high, and the addresses hold until the next start. Exactly one of `permitStb` and `faultFlag` pulses for one cycle after each start. Both are 0 in a cycle that follows no start.
- R5: The limit check runs only when `checkEn` is 1, instruction bits [19:16] equal 13 (the stack pointer) and instruction bit 21 (base update) is 1. Otherwise the result is always a permit, whatever the addresses.
- R6: A violation is an unsigned 32-bit comparison where the lowest address is strictly less than `stackLimit`. A checked violation gives `faultFlag`=1 and `permitStb`=0. `permitStb` and `faultFlag` are never high together.
- R7: A checked transfer whose lowest address is greater than or equal to the limit gives `permitStb`=1 and `faultFlag`=0.
- R8: In the increment form, the compared address is the original stack pointer. A stack pointer below the limit faults even though the update moves it upward.
- R9: An empty register mask gives a size of 0. `startAddr` and `wbValue` are then the base, and the check still runs on the base.
- R10: `wbFlag` is a registered copy of instruction bit 21, updated with each start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | One-cycle strobe: the instruction inputs are valid |
| checkEn | input | 1 | Stack limit checking is enabled |
| instrWord | input | 32 | 32-bit block transfer instruction |
| baseVal | input | 32 | Current value of the base register |
| stackLimit | input | 32 | Programmed stack limit |
| startAddr | output | 32 | Lowest address of the transfer |
| wbValue | output | 32 | Final base value for write-back |
| wbFlag | output | 1 | Base update requested |
| permitStb | output | 1 | One-cycle pulse: beats may be issued |
| faultFlag | output | 1 | One-cycle pulse: limit violated, no beat may be issued |

## Verification
Stimulus covers both directions with masks of different population counts. This separates the increment and decrement address arithmetic and the size computation. Stack-pointer transfers are placed below, exactly at, and above the limit. They separate the strict comparison from an inclusive one, and a limit near 0x8000_0000 separates an unsigned compare from a signed one. Each gating term (enable, base index, update bit) is cleared in turn with an otherwise failing address, which shows the check is bypassed. The cases also include an upward-moving stack pointer already below the limit, an empty mask, and back-to-back starts separated by idle cycles, which shows the verdict is one pulse per start.

// File: rtl/lsm_guard_pkg.sv
package lsm_guard_pkg;
  // Strobes from the control decoder to the address datapath
  typedef struct packed {
    logic load;      // capture a new instruction
    logic decBefore; // decrement-before form
    logic wback;     // base register update requested
  } guardCtrl_t;
endpackage

// File: rtl/lsm_guard_ctrl.sv
module lsm_guard_ctrl
  import lsm_guard_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int RN_LSB  = 16,
  parameter int RN_W    = 4,
  parameter int SP_IDX  = 13,
  parameter int WB_BIT  = 21,
  parameter int DB_BIT  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStb,
  input  logic               checkEn,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               belowLimit,
  output guardCtrl_t         ctrl,
  output logic               permitStb,
  output logic               faultFlag
);
  logic baseIsSp;
  logic checkOn;
  logic violate;

  always_comb begin
    ctrl.load      = startStb;
    ctrl.decBefore = instrWord[DB_BIT];
    ctrl.wback     = instrWord[WB_BIT];
  end

  assign baseIsSp = (instrWord[RN_LSB +: RN_W] == RN_W'(SP_IDX));
  assign checkOn  = checkEn & baseIsSp & ctrl.wback;
  assign violate  = checkOn & belowLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      permitStb <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      permitStb <= startStb & ~violate;
      faultFlag <= startStb & violate;
    end
  end
endmodule

// File: rtl/lsm_guard_dp.sv
module lsm_guard_dp
  import lsm_guard_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardCtrl_t        ctrl,
  input  logic [LIST_W-1:0] regList,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] stackLimit,
  output logic              belowLimit,
  output logic [DATA_W-1:0] startAddr,
  output logic [DATA_W-1:0] wbValue,
  output logic              wbFlag
);
  localparam int CNT_W      = $clog2(LIST_W + 1);
  localparam int BYTE_SHIFT = $clog2(WORD_BYTES);

  logic [CNT_W-1:0]  regCount;
  logic [DATA_W-1:0] sizeBytes;
  logic [DATA_W-1:0] downBase;
  logic [DATA_W-1:0] upBase;
  logic [DATA_W-1:0] lowAddr;
  logic [DATA_W-1:0] finalBase;

  always_comb begin
    regCount = '0;
    for (int i = 0; i < LIST_W; i++) begin
      regCount = regCount + CNT_W'(regList[i]);
    end
  end

  assign sizeBytes  = DATA_W'(regCount) << BYTE_SHIFT;
  assign downBase   = baseVal - sizeBytes;
  assign upBase     = baseVal + sizeBytes;
  assign lowAddr    = ctrl.decBefore ? downBase : baseVal;
  assign finalBase  = ctrl.decBefore ? downBase : upBase;
  assign belowLimit = (lowAddr < stackLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      wbValue   <= '0;
      wbFlag    <= 1'b0;
    end else if (ctrl.load) begin
      startAddr <= lowAddr;
      wbValue   <= finalBase;
      wbFlag    <= ctrl.wback;
    end
  end
endmodule

// File: rtl/lsm_stack_guard.sv
module lsm_stack_guard
  import lsm_guard_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4,
  parameter int RN_LSB     = 16,
  parameter int RN_W       = 4,
  parameter int SP_IDX     = 13,
  parameter int WB_BIT     = 21,
  parameter int DB_BIT     = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              checkEn,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] stackLimit,
  output logic [DATA_W-1:0] startAddr,
  output logic [DATA_W-1:0] wbValue,
  output logic              wbFlag,
  output logic              permitStb,
  output logic              faultFlag
);
  guardCtrl_t ctrl;
  logic       belowLimit;

  lsm_guard_ctrl #(
    .INSTR_W(DATA_W), .RN_LSB(RN_LSB), .RN_W(RN_W),
    .SP_IDX(SP_IDX), .WB_BIT(WB_BIT), .DB_BIT(DB_BIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .checkEn(checkEn),
    .instrWord(instrWord), .belowLimit(belowLimit), .ctrl(ctrl),
    .permitStb(permitStb), .faultFlag(faultFlag)
  );

  lsm_guard_dp #(
    .DATA_W(DATA_W), .LIST_W(LIST_W), .WORD_BYTES(WORD_BYTES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .regList(instrWord[LIST_W-1:0]),
    .baseVal(baseVal), .stackLimit(stackLimit), .belowLimit(belowLimit),
    .startAddr(startAddr), .wbValue(wbValue), .wbFlag(wbFlag)
  );
endmodule

// File: rtl/lsm_guard_chk.sv
module lsm_guard_chk #(
  parameter int DATA_W = 32,
  parameter int WB_BIT = 21,
  parameter int DB_BIT = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              startStb,
  input logic              checkEn,
  input logic [DATA_W-1:0] instrWord,
  input logic [DATA_W-1:0] baseVal,
  input logic [DATA_W-1:0] startAddr,
  input logic              wbFlag,
  input logic              permitStb,
  input logic              faultFlag
);
  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(permitStb && faultFlag)); // R6
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (permitStb ^ faultFlag)); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !startStb |=> (!permitStb && !faultFlag)); // R4
  AST_BYPASS_PERMIT: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && (!checkEn || !instrWord[WB_BIT])) |=> permitStb); // R5
  AST_WB_COPY: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (wbFlag == $past(instrWord[WB_BIT]))); // R10
  AST_INC_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !instrWord[DB_BIT]) |=> (startAddr == $past(baseVal))); // R2
  AST_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && (instrWord[15:0] == 16'h0)) |=> (startAddr == $past(baseVal))); // R9
endmodule

bind lsm_stack_guard lsm_guard_chk #(.DATA_W(DATA_W), .WB_BIT(WB_BIT), .DB_BIT(DB_BIT)) chk_i (
  .clk(clk), .rstN(rstN), .startStb(startStb), .checkEn(checkEn),
  .instrWord(instrWord), .baseVal(baseVal), .startAddr(startAddr),
  .wbFlag(wbFlag), .permitStb(permitStb), .faultFlag(faultFlag)
);

// File: tb/lsm_stack_guard_tb_top.sv
module lsm_stack_guard_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStb = 1'b0;
  logic        checkEn = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] baseVal = '0;
  logic [31:0] stackLimit = '0;
  logic [31:0] startAddr, wbValue;
  logic        wbFlag, permitStb, faultFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit monOn = 1'b0;
  logic startSeen = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] wb;
    logic        wbf;
    logic        fault;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk; // 200 MHz

  lsm_stack_guard dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .checkEn(checkEn),
    .instrWord(instrWord), .baseVal(baseVal), .stackLimit(stackLimit),
    .startAddr(startAddr), .wbValue(wbValue), .wbFlag(wbFlag),
    .permitStb(permitStb), .faultFlag(faultFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(input bit db, input bit wb,
                                          input logic [3:0] rn, input logic [15:0] list);
    return {7'b1110100, db, 2'b00, wb, 1'b0, rn, list};
  endfunction

  // Driver: call at a falling edge; leaves startStb high for one cycle
  task automatic issue(input string tag, input bit en, input logic [31:0] ins,
                       input logic [31:0] base, input logic [31:0] lim);
    expItem_t it;
    logic [31:0] sz;
    logic        chk;
    sz = 32'($countones(ins[15:0])) * 32'd4;
    it.addr  = ins[24] ? base - sz : base;
    it.wb    = ins[24] ? base - sz : base + sz;
    it.wbf   = ins[21];
    chk      = en && (ins[19:16] == 4'd13) && ins[21];
    it.fault = chk && (it.addr < lim);
    it.tag   = tag;
    checkEn = en; instrWord = ins; baseVal = base; stackLimit = lim;
    startStb = 1'b1;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    startStb = 1'b0;
    instrWord = $urandom();
    baseVal = $urandom();
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) startSeen <= rstN && startStb;

  // Monitor: compares at falling edges, half a cycle after outputs update
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (startSeen) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R4", "no expected item", 32'd0, 32'd1);
          end else begin
            expItem_t e;
            e = expQ.pop_front();
            check(startAddr == e.addr, e.tag, "startAddr", startAddr, e.addr);
            check(wbValue == e.wb, e.tag, "wbValue", wbValue, e.wb);
            check(wbFlag == e.wbf, {e.tag, "/R10"}, "wbFlag", 32'(wbFlag), 32'(e.wbf));
            check(faultFlag == e.fault, e.tag, "faultFlag", 32'(faultFlag), 32'(e.fault));
            check(permitStb == !e.fault, {e.tag, "/R7"}, "permitStb", 32'(permitStb), 32'(!e.fault));
          end
        end else begin
          check(!permitStb && !faultFlag, "R4", "idle verdict",
                {30'd0, permitStb, faultFlag}, 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!permitStb && !faultFlag && startAddr == 0 && wbValue == 0 && !wbFlag,
          "R1", "in reset", startAddr | wbValue | {29'd0, wbFlag, permitStb, faultFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!permitStb && !faultFlag && startAddr == 0 && wbValue == 0 && !wbFlag,
          "R1", "after reset", startAddr | wbValue | {29'd0, wbFlag, permitStb, faultFlag}, 32'd0);
    monOn = 1'b1;
    // R2 increment form, non-SP base
    issue("R2", 1'b1, mkInstr(1'b0, 1'b1, 4'd2, 16'h00F0), 32'h2000_1000, 32'h2000_0000);
    idle(1);
    // R3 decrement form on SP, inside the stack
    issue("R3", 1'b1, mkInstr(1'b1, 1'b1, 4'd13, 16'h4FF0), 32'h2000_0100, 32'h2000_0000);
    // R6 decrement below limit, back to back
    issue("R6", 1'b1, mkInstr(1'b1, 1'b1, 4'd13, 16'h00FF), 32'h2000_0010, 32'h2000_0000);
    // R8 incrementing SP already below limit
    issue("R8", 1'b1, mkInstr(1'b0, 1'b1, 4'd13, 16'h000F), 32'h1FFF_FFF0, 32'h2000_0000);
    idle(2);
    // R5 bypass: no base update, checking off, non-SP base
    issue("R5", 1'b1, mkInstr(1'b1, 1'b0, 4'd13, 16'h00FF), 32'h2000_0010, 32'h2000_0000);
    issue("R5", 1'b0, mkInstr(1'b1, 1'b1, 4'd13, 16'h00FF), 32'h2000_0010, 32'h2000_0000);
    issue("R5", 1'b1, mkInstr(1'b1, 1'b1, 4'd12, 16'h00FF), 32'h2000_0010, 32'h2000_0000);
    idle(1);
    // R9 empty list below limit, then exactly at limit
    issue("R9", 1'b1, mkInstr(1'b0, 1'b1, 4'd13, 16'h0000), 32'h1FFF_FFFC, 32'h2000_0000);
    issue("R9", 1'b1, mkInstr(1'b1, 1'b1, 4'd13, 16'h0000), 32'h2000_0000, 32'h2000_0000);
    // R7 lowest address exactly at the limit
    issue("R7", 1'b1, mkInstr(1'b1, 1'b1, 4'd13, 16'h0003), 32'h2000_0008, 32'h2000_0000);
    // R6 one word below the limit
    issue("R6", 1'b1, mkInstr(1'b1, 1'b1, 4'd13, 16'h0007), 32'h2000_0008, 32'h2000_0000);
    // R6 unsigned compare across the sign boundary
    issue("R6", 1'b1, mkInstr(1'b0, 1'b1, 4'd13, 16'h8001), 32'h7FFF_FFFC, 32'h8000_0000);
    issue("R7", 1'b1, mkInstr(1'b0, 1'b1, 4'd13, 16'h8001), 32'h8000_0004, 32'h8000_0000);
    // R3 wrap-around of the decrement with a full list
    issue("R3", 1'b1, mkInstr(1'b1, 1'b1, 4'd3, 16'hFFFF), 32'h0000_0020, 32'h0000_0000);
    idle(3);
    // R4 addresses hold after idle cycles
    check(startAddr == 32'hFFFF_FFE0, "R4", "startAddr hold", startAddr, 32'hFFFF_FFE0);
    check(wbValue == 32'hFFFF_FFE0, "R4", "wbValue hold", wbValue, 32'hFFFF_FFE0);
    check(expQ.size() == 0, "R4", "leftover items", 32'(expQ.size()), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule